// File: doc/BRIEF.md
# Core Address Translation and Request Steering Unit

This unit sits between one processor core and the tile's outbound paths. Every core request carries a 32-bit core address. The top byte of that address selects one of 256 translation entries, so each entry covers a 16 MB window. The entry supplies the upper bits of a 34-bit system address and also says where the request is going: a destination tile given as (y,x), a router sub-port code, and a bypass flag that sends the access straight to the local tile's message buffer.

Each translated request is placed into exactly one of three outbound queue ports: the mesh router, the local message buffer, or the local configuration registers. Each queue port has a valid/ready handshake. When the queue a request needs cannot take it, the core port holds ready low and nothing is lost.

The table comes out of reset holding a default image. Software can replace any entry through a write port, at boot or while traffic is running.

Top module: `addr_xlate`

## Requirements
- R1: While reset is high and in the cycle after it is released, every q_valid bit is 0 and req_ready is 1.
- R2: A request is accepted when req_valid and req_ready are both high at a rising clock edge. Its table index is req_addr[31:24]. The system address is {entry[9:0], req_addr[23:0]}. The entry field layout is [21:19] sub-port, [18:11] destination tile {y[3:0], x[3:0]}, [10] bypass and [9:0] upper address. Queue index 0 is the router, 1 is the message buffer and 2 is the configuration queue.
- R3: In the default image, entry 192+t for t in 0..23 has bypass 0, sub-port 3, upper address 0 and destination tile x = t mod 6, y = t div 6. Entry 216 has bypass 1, sub-port 3, destination 0 and upper address 0.
- R4: In the default image, entry 224+t for t in 0..23 has sub-port 2, bypass 0, upper address 0 and the same tile numbering as R3. Entry 248 has sub-port 2 and destination equal to the local tile. The default local tile is x=2, y=1, which is tile code 0x12.
- R5: Every other default entry has bypass 0, sub-port 6, destination 0 and upper address equal to the entry index.
- R6: A request whose entry has bypass set goes to queue 1. On that queue, q_dest shows the local tile code whatever destination the entry holds.
- R7: A request whose entry has bypass clear goes to queue 2 only when its destination equals the local tile and its sub-port is 2. Every other such request goes to queue 0 and carries the entry's destination.
- R8: A table write (tbl_we high at a clock edge) replaces entry tbl_idx with tbl_entry for every request accepted at a later edge. The last write to an entry wins.
- R9: While a queue holds an item with its ready low, the item stays on the port unchanged. Once a request that needs that queue is waiting internally, req_ready is 0. No request is dropped, and items leave each queue in acceptance order.
- R10: q_we and q_wdata repeat the request's req_we and req_wdata. q_sub repeats the entry's sub-port code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Unit can accept a core request |
| req_addr | input | 32 | Core address |
| req_we | input | 1 | Request is a write |
| req_wdata | input | 32 | Write data |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | 8 | Table entry index to write |
| tbl_entry | input | 22 | New table entry value |
| q_valid | output | 3 | Per-queue item valid (0 router, 1 message buffer, 2 configuration) |
| q_ready | input | 3 | Per-queue sink ready |
| q_sysaddr | output | 3x34 | Per-queue translated system address |
| q_dest | output | 3x8 | Per-queue destination tile {y,x} |
| q_sub | output | 3x3 | Per-queue router sub-port code |
| q_we | output | 3 | Per-queue write flag |
| q_wdata | output | 3x32 | Per-queue write data |

## Verification
A corrupted table entry or a wrong default image shows up in the first request to that window. It appears as a wrong system address, a wrong destination, or an item on the wrong queue, about two clocks after acceptance. A steering fault would place a local-configuration access on the router or put a bypass access anywhere but the message buffer, and the per-queue scoreboard flags it at the handshake. A flow-control fault shows as an item that changes or vanishes while its queue is stalled, or as req_ready staying high behind a blocked queue. Holding one queue blocked for several cycles exposes either fault within that window.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int CA_W  = 32;
  localparam int IDX_W = 8;
  localparam int LO_W  = CA_W - IDX_W;
  localparam int HI_W  = 10;
  localparam int SYS_W = HI_W + LO_W;
  localparam int ENT_W = 22;
  localparam int NQ    = 3;

  typedef struct packed {
    logic [2:0]      sub;
    logic [7:0]      dest;
    logic            byp;
    logic [HI_W-1:0] hi;
  } ent_t;

  typedef enum logic [1:0] {Q_RTR = 2'd0, Q_MSG = 2'd1, Q_CFG = 2'd2} qsel_e;

  localparam logic [2:0] SUB_CFG  = 3'd2;
  localparam logic [2:0] SUB_MSG  = 3'd3;
  localparam logic [2:0] SUB_WEST = 3'd6;
endpackage

// File: rtl/xlate_table.sv
module xlate_table
  import xlate_pkg::*;
#(
  parameter int GRID_X = 6,
  parameter int GRID_Y = 4,
  parameter int MSG_BASE = 192,
  parameter int CFG_BASE = 224,
  parameter logic [7:0] LOCAL_TILE = 8'h12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output ent_t             rd_ent,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  ent_t             wr_ent
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int NT    = GRID_X * GRID_Y;

  ent_t             mem [DEPTH];
  ent_t             ram_q;
  logic [DEPTH-1:0] touched;
  logic             tch_q;
  logic [IDX_W-1:0] idx_q;

  function automatic ent_t dflt(input logic [IDX_W-1:0] idx);
    ent_t e;
    int i;
    int t;
    i = int'(idx);
    e = '0;
    if (i >= MSG_BASE && i < MSG_BASE + NT) begin
      t = i - MSG_BASE;
      e.sub  = SUB_MSG;
      e.dest = {4'(t / GRID_X), 4'(t % GRID_X)};
    end else if (i == MSG_BASE + NT) begin
      e.sub = SUB_MSG;
      e.byp = 1'b1;
    end else if (i >= CFG_BASE && i < CFG_BASE + NT) begin
      t = i - CFG_BASE;
      e.sub  = SUB_CFG;
      e.dest = {4'(t / GRID_X), 4'(t % GRID_X)};
    end else if (i == CFG_BASE + NT) begin
      e.sub  = SUB_CFG;
      e.dest = LOCAL_TILE;
    end else begin
      e.sub = SUB_WEST;
      e.hi  = HI_W'(i);
    end
    return e;
  endfunction

  // plain read-first RAM, no reset, so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_ent;
    if (rd_en) ram_q <= mem[rd_idx];
  end

  // per-entry flag: has software overwritten the default image
  always_ff @(posedge clk) begin
    if (rst) begin
      touched <= '0;
      tch_q   <= 1'b0;
      idx_q   <= '0;
    end else begin
      if (wr_en) touched[wr_idx] <= 1'b1;
      if (rd_en) begin
        tch_q <= touched[rd_idx];
        idx_q <= rd_idx;
      end
    end
  end

  assign rd_ent = tch_q ? ram_q : dflt(idx_q);

  // R8
  load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> touched[$past(wr_idx)]);
endmodule

// File: rtl/xlate_steer.sv
module xlate_steer
  import xlate_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [7:0] LOCAL_TILE = 8'h12
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_v,
  input  ent_t                        in_ent,
  input  logic [LO_W-1:0]             in_lo,
  input  logic                        in_we,
  input  logic [DATA_W-1:0]           in_data,
  output logic                        in_adv,
  output logic [NQ-1:0]               qv_o,
  input  logic [NQ-1:0]               qr_i,
  output logic [NQ-1:0][SYS_W-1:0]    qaddr_o,
  output logic [NQ-1:0][7:0]          qdest_o,
  output logic [NQ-1:0][2:0]          qsub_o,
  output logic [NQ-1:0]               qwe_o,
  output logic [NQ-1:0][DATA_W-1:0]   qdata_o
);
  qsel_e         sel;
  logic [7:0]    dest_out;
  logic [NQ-1:0] free;

  always_comb begin
    if (in_ent.byp)                                          sel = Q_MSG;
    else if (in_ent.dest == LOCAL_TILE && in_ent.sub == SUB_CFG) sel = Q_CFG;
    else                                                     sel = Q_RTR;
    dest_out = in_ent.byp ? LOCAL_TILE : in_ent.dest;
  end

  assign in_adv = in_v && free[sel];

  for (genvar k = 0; k < NQ; k++) begin : g_q
    logic              v_q;
    logic [SYS_W-1:0]  a_q;
    logic [7:0]        d_q;
    logic [2:0]        s_q;
    logic              w_q;
    logic [DATA_W-1:0] x_q;
    logic              push;

    assign free[k] = !v_q || qr_i[k];
    assign push    = in_adv && (int'(sel) == k);

    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= 1'b0;
      end else if (push) begin
        v_q <= 1'b1;
      end else if (qr_i[k]) begin
        v_q <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (push) begin
        a_q <= {in_ent.hi, in_lo};
        d_q <= dest_out;
        s_q <= in_ent.sub;
        w_q <= in_we;
        x_q <= in_data;
      end
    end

    assign qv_o[k]    = v_q;
    assign qaddr_o[k] = a_q;
    assign qdest_o[k] = d_q;
    assign qsub_o[k]  = s_q;
    assign qwe_o[k]   = w_q;
    assign qdata_o[k] = x_q;

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
      qv_o[k] && !qr_i[k] |=> qv_o[k] && $stable(qaddr_o[k]) && $stable(qdata_o[k]));
  end

  // R7
  cfg_target_chk: assert property (@(posedge clk) disable iff (rst)
    qv_o[Q_CFG] |-> qdest_o[Q_CFG] == LOCAL_TILE && qsub_o[Q_CFG] == SUB_CFG);

  // R7
  rtr_target_chk: assert property (@(posedge clk) disable iff (rst)
    qv_o[Q_RTR] |-> !(qdest_o[Q_RTR] == LOCAL_TILE && qsub_o[Q_RTR] == SUB_CFG));

  // R6
  msg_dest_chk: assert property (@(posedge clk) disable iff (rst)
    qv_o[Q_MSG] |-> qdest_o[Q_MSG] == LOCAL_TILE);
endmodule

// File: rtl/addr_xlate.sv
module addr_xlate
  import xlate_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int GRID_X   = 6,
  parameter int GRID_Y   = 4,
  parameter int TILE_X   = 2,
  parameter int TILE_Y   = 1,
  parameter int MSG_BASE = 192,
  parameter int CFG_BASE = 224
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [CA_W-1:0]            req_addr,
  input  logic                       req_we,
  input  logic [DATA_W-1:0]          req_wdata,
  input  logic                       tbl_we,
  input  logic [IDX_W-1:0]           tbl_idx,
  input  logic [ENT_W-1:0]           tbl_entry,
  output logic [NQ-1:0]              q_valid,
  input  logic [NQ-1:0]              q_ready,
  output logic [NQ-1:0][SYS_W-1:0]   q_sysaddr,
  output logic [NQ-1:0][7:0]         q_dest,
  output logic [NQ-1:0][2:0]         q_sub,
  output logic [NQ-1:0]              q_we,
  output logic [NQ-1:0][DATA_W-1:0]  q_wdata
);
  localparam logic [7:0] LOCAL_TILE = {4'(TILE_Y), 4'(TILE_X)};

  logic              accept;
  logic              s1_v;
  logic              s1_adv;
  logic [LO_W-1:0]   s1_lo;
  logic              s1_we;
  logic [DATA_W-1:0] s1_data;
  ent_t              s1_ent;

  assign req_ready = !s1_v || s1_adv;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
    end else if (accept) begin
      s1_v <= 1'b1;
    end else if (s1_adv) begin
      s1_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      s1_lo   <= req_addr[LO_W-1:0];
      s1_we   <= req_we;
      s1_data <= req_wdata;
    end
  end

  xlate_table #(
    .GRID_X(GRID_X), .GRID_Y(GRID_Y), .MSG_BASE(MSG_BASE),
    .CFG_BASE(CFG_BASE), .LOCAL_TILE(LOCAL_TILE)
  ) u_tab (
    .clk(clk), .rst(rst),
    .rd_en(accept), .rd_idx(req_addr[CA_W-1:LO_W]), .rd_ent(s1_ent),
    .wr_en(tbl_we), .wr_idx(tbl_idx), .wr_ent(ent_t'(tbl_entry))
  );

  xlate_steer #(.DATA_W(DATA_W), .LOCAL_TILE(LOCAL_TILE)) u_steer (
    .clk(clk), .rst(rst),
    .in_v(s1_v), .in_ent(s1_ent), .in_lo(s1_lo), .in_we(s1_we),
    .in_data(s1_data), .in_adv(s1_adv),
    .qv_o(q_valid), .qr_i(q_ready), .qaddr_o(q_sysaddr), .qdest_o(q_dest),
    .qsub_o(q_sub), .qwe_o(q_we), .qdata_o(q_wdata)
  );

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> s1_v);

  // R1
  rst_chk: assert property (@(posedge clk)
    $past(rst) |-> q_valid == '0);
endmodule

// File: tb/sim_addr_xlate.sv
module sim_addr_xlate;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] LOC = 8'h12;
  localparam int WD_LIMIT = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic req_we = 1'b0;
  logic [31:0] req_wdata = '0;
  logic req_ready;
  logic tbl_we = 1'b0;
  logic [7:0] tbl_idx = '0;
  logic [21:0] tbl_entry = '0;
  logic [2:0] q_valid;
  logic [2:0] q_ready = 3'b111;
  logic [2:0][33:0] q_sysaddr;
  logic [2:0][7:0] q_dest;
  logic [2:0][2:0] q_sub;
  logic [2:0] q_we;
  logic [2:0][31:0] q_wdata;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int rdy_mode = 0;

  typedef struct {
    logic [33:0] a;
    logic [7:0]  d;
    logic [2:0]  s;
    logic        we;
    logic [31:0] w;
    int          q;
    string       tag;
  } exp_t;

  exp_t sbr[$];
  exp_t sbm[$];
  exp_t sbc[$];
  logic [21:0] tab [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_xlate u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_entry(tbl_entry),
    .q_valid(q_valid), .q_ready(q_ready), .q_sysaddr(q_sysaddr),
    .q_dest(q_dest), .q_sub(q_sub), .q_we(q_we), .q_wdata(q_wdata)
  );

  // default image as stated in R3, R4, R5
  function automatic logic [21:0] def_ent(input int i);
    int t;
    if (i >= 192 && i <= 215) begin
      t = i - 192;
      return {3'd3, 4'(t / 6), 4'(t % 6), 1'b0, 10'd0};
    end
    if (i == 216) return {3'd3, 8'h00, 1'b1, 10'd0};
    if (i >= 224 && i <= 247) begin
      t = i - 224;
      return {3'd2, 4'(t / 6), 4'(t % 6), 1'b0, 10'd0};
    end
    if (i == 248) return {3'd2, LOC, 1'b0, 10'd0};
    return {3'd6, 8'h00, 1'b0, 10'(i)};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] a, input logic we, input logic [31:0] d,
                      input string tag);
    exp_t e;
    logic [21:0] en;
    en = tab[a[31:24]];
    e.a = {en[9:0], a[23:0]};
    e.s = en[21:19];
    e.we = we;
    e.w = d;
    e.tag = tag;
    if (en[10]) begin
      e.q = 1; e.d = LOC;
    end else if (en[18:11] == LOC && en[21:19] == 3'd2) begin
      e.q = 2; e.d = en[18:11];
    end else begin
      e.q = 0; e.d = en[18:11];
    end
    case (e.q)
      0: sbr.push_back(e);
      1: sbm.push_back(e);
      default: sbc.push_back(e);
    endcase
    @(negedge clk); #2;
    req_valid = 1'b1; req_addr = a; req_we = we; req_wdata = d;
    while (!req_ready) begin @(negedge clk); #2; end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic twrite(input logic [7:0] idx, input logic [21:0] en);
    @(negedge clk); #2;
    tbl_we = 1'b1; tbl_idx = idx; tbl_entry = en;
    @(posedge clk); #1;
    tbl_we = 1'b0;
    tab[idx] = en;
  endtask

  task automatic drain();
    for (int n = 0; n < 300; n++) begin
      if (sbr.size() == 0 && sbm.size() == 0 && sbc.size() == 0) break;
      @(negedge clk);
    end
    check(sbr.size() == 0 && sbm.size() == 0 && sbc.size() == 0, "R9",
          "items still pending", 64'(sbr.size() + sbm.size() + sbc.size()), 64'd0);
  endtask

  // monitor: set sink readiness, then compare every item that will transfer
  initial begin
    forever begin
      @(negedge clk);
      case (rdy_mode)
        0: q_ready = 3'b111;
        1: q_ready = 3'($urandom);
        default: q_ready = 3'b110;
      endcase
      #1;
      if (!rst) begin
        for (int k = 0; k < 3; k++) begin
          if (q_valid[k] && q_ready[k]) begin
            exp_t e;
            bit empty;
            empty = (k == 0) ? (sbr.size() == 0) : (k == 1) ? (sbm.size() == 0) : (sbc.size() == 0);
            if (empty) begin
              check(1'b0, "R7", $sformatf("unexpected item on queue %0d", k),
                    64'(q_sysaddr[k]), 64'd0);
            end else begin
              case (k)
                0: e = sbr.pop_front();
                1: e = sbm.pop_front();
                default: e = sbc.pop_front();
              endcase
              check(q_sysaddr[k] == e.a && q_dest[k] == e.d && q_sub[k] == e.s &&
                    q_we[k] == e.we && q_wdata[k] == e.w, e.tag,
                    $sformatf("queue %0d item {addr,dest,sub,we,data}", k),
                    {q_sysaddr[k][29:0], q_dest[k], q_sub[k], q_we[k], q_wdata[k][21:0]},
                    {e.a[29:0], e.d, e.s, e.we, e.w[21:0]});
            end
          end
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT) begin
      fails++;
      checks++;
      $display("FAIL R9 watchdog: cycles %0d expected below %0d", cycles, WD_LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) tab[i] = def_ent(i);
    rst = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    check(q_valid == 3'b000, "R1", "q_valid during reset", 64'(q_valid), 64'd0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(q_valid == 3'b000, "R1", "q_valid after reset", 64'(q_valid), 64'd0);
    check(req_ready == 1'b1, "R1", "req_ready after reset", 64'(req_ready), 64'd1);

    // default private windows
    send(32'h0512_3456, 1'b0, 32'h0, "R5");
    send(32'h3FAB_CDEF, 1'b1, 32'hDEAD_BEEF, "R10");
    send(32'hFF00_0001, 1'b0, 32'h1, "R5");
    send(32'h0000_0000, 1'b1, 32'h5555_AAAA, "R2");
    // default message buffer windows
    send(32'hC000_0010, 1'b0, 32'h0, "R3");
    send(32'hC700_1234, 1'b1, 32'h0123_4567, "R3");
    send(32'hD700_3FFF, 1'b0, 32'h0, "R3");
    send(32'hD800_0100, 1'b1, 32'h0000_00AA, "R6");
    // default configuration windows
    send(32'hE000_0100, 1'b0, 32'h0, "R4");
    send(32'hE800_0100, 1'b1, 32'hCAFE_0001, "R4");
    send(32'hF800_0100, 1'b0, 32'h0, "R4");
    send(32'hF700_0080, 1'b0, 32'h0, "R4");
    drain();

    // rewritten entries
    twrite(8'h10, {3'd5, 8'h35, 1'b1, 10'h2AA});
    send(32'h1000_0040, 1'b0, 32'h0, "R6");
    twrite(8'h11, {3'd5, LOC, 1'b0, 10'h001});
    send(32'h1100_0040, 1'b0, 32'h0, "R7");
    twrite(8'h12, {3'd2, 8'h13, 1'b0, 10'h002});
    send(32'h1200_0040, 1'b1, 32'h77, "R7");
    twrite(8'h13, {3'd2, LOC, 1'b0, 10'h3FF});
    send(32'h13FF_FFFF, 1'b1, 32'h88, "R8");
    twrite(8'h13, {3'd4, 8'h05, 1'b0, 10'h155});
    send(32'h1300_0000, 1'b0, 32'h0, "R8");
    twrite(8'hE8, {3'd6, 8'h20, 1'b0, 10'h100});
    send(32'hE800_0004, 1'b0, 32'h0, "R8");
    drain();

    // router queue blocked: later request must wait, item must stay
    rdy_mode = 2;
    send(32'h0100_0001, 1'b0, 32'h1, "R9");
    send(32'h0200_0002, 1'b0, 32'h2, "R9");
    fork
      send(32'h0300_0003, 1'b0, 32'h3, "R9");
    join_none
    repeat (4) @(negedge clk);
    #3;
    check(req_ready == 1'b0, "R9", "req_ready behind blocked queue", 64'(req_ready), 64'd0);
    check(q_valid[0] == 1'b1, "R9", "router item held", 64'(q_valid[0]), 64'd1);
    check(q_sysaddr[0] == {10'h001, 24'h000001}, "R9", "held router address",
          64'(q_sysaddr[0]), 64'({10'h001, 24'h000001}));
    rdy_mode = 0;
    wait fork;
    drain();

    // mixed traffic under random sink readiness
    rdy_mode = 1;
    for (int n = 0; n < 60; n++) begin
      logic [7:0] idx;
      case (n % 6)
        0: idx = 8'(192 + ($urandom % 25));
        1: idx = 8'(224 + ($urandom % 25));
        2: idx = 8'h10;
        3: idx = 8'h11;
        4: idx = 8'h13;
        default: idx = 8'($urandom);
      endcase
      send({idx, 24'($urandom)}, 1'($urandom), $urandom, "R9");
      if (n == 30) twrite(8'h11, {3'd2, LOC, 1'b0, 10'h0F0});
    end
    rdy_mode = 0;
    drain();
    repeat (3) @(negedge clk);
    #1;
    check(q_valid == 3'b000, "R9", "queues empty at end", 64'(q_valid), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule